// File: doc/BRIEF.md
# PPS-Aligned Clock-Chip SYNC Pulse Generator

This block drives the SYNC input of an external PLL clock chip so that the chip realigns its outputs to its reference. Software arms it with a rising edge on a trigger input. The block then waits for the next rising edge of the pulse-per-second reference. On that edge it drives one high pulse whose length is set by a parameter and counted in the core clock. At 200 MHz the default is 400000 cycles, which is 2 ms. The pulse can never be set shorter than 1 ms.

The PPS input is asynchronous to the core clock. It is synchronized before its rising edge is detected. The trigger input can be synchronized the same way, or it can be used directly when it already comes from the core clock domain.

A separate active-high counter-clear input returns the block to idle from any state. The intended order is: configure the clock chip, pulse the counter clear, then raise the trigger. A busy status shows that the block is armed or pulsing. A done flag reports that a pulse has completed.

Top module: `ppsalign_sync_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `sync_o`, `busy_o` and `done_o` are 0.
- R2: A low-to-high transition on `trig_i` in the idle state arms the block. `busy_o` becomes 1 on the third rising clock edge after `trig_i` goes high (two synchronizer stages plus the state register).
- R3: `sync_o` rises only on a PPS rising edge that arrives while the block is armed. A PPS edge seen in the same cycle as the arming trigger edge does not start a pulse.
- R4: `sync_o` stays high for exactly `PULSE_CYCLES` core-clock cycles, unless `cnt_clr_i` ends the pulse early.
- R5: Elaboration fails if `PULSE_CYCLES` is below `CLK_HZ/1000`, that is, shorter than 1 ms.
- R6: Trigger edges that arrive while the block is armed or pulsing are ignored. The block stays armed, and the pulse length does not change.
- R7: `done_o` becomes 1 when a pulse ends, at the same edge on which `sync_o` falls. It stays 1 until the next arming trigger edge or until `cnt_clr_i` is asserted.
- R8: After a pulse, the block returns to idle only when the synchronized trigger is low. PPS edges that arrive while the trigger is still held high produce no further pulse.
- R9: `cnt_clr_i` is sampled on the clock edge. After one edge with it high, the block is idle, and `sync_o`, `busy_o` and `done_o` are all 0.
- R10: PPS rising edges that arrive while the block is idle are ignored.
- R11: `busy_o` is 1 exactly while the block is armed or pulsing.
- R12: PPS passes through a two-flop synchronizer, and its rising edge becomes a one-cycle pulse. `sync_o` rises on the third rising clock edge after `pps_i` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr_i | input | 1 | Synchronous counter clear, active high; returns the block to idle |
| trig_i | input | 1 | Arm trigger; a rising edge arms the block |
| pps_i | input | 1 | Pulse-per-second reference, asynchronous |
| sync_o | output | 1 | SYNC pulse to the clock chip, active high |
| busy_o | output | 1 | High while armed or pulsing |
| done_o | output | 1 | Sticky flag that a pulse has completed |

## Verification
A table sets the delay between the trigger and the PPS edge. With no delay, the PPS edge arrives before the block is armed, so it must be ignored. With delays of one cycle and more, the first PPS edge after arming must start a pulse with the exact latency and length. Further cases cover the following:
- a second PPS edge while the trigger is still held high, which must not start a new pulse;
- trigger toggles during the armed and pulsing states, which must be ignored;
- a PPS edge while idle, which must be ignored;
- a counter clear in the middle of a pulse.

Each case separates one of these: a block that pulses on the command itself, one that retriggers, one that restarts its counter, and one that ignores the clear.

// File: rtl/ppsalign_pkg.sv
package ppsalign_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_PULSE = 2'd2,
      ST_DONE  = 2'd3
   } sync_state_e;

endpackage

// File: rtl/ppsalign_edge.sv
// Level synchronizer (optional) plus one-cycle rising-edge pulse.
module ppsalign_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o
);

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl_o = d_i;
      end else begin : g_sync
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign lvl_o = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;

   // R12: the edge pulse lasts exactly one cycle
   assert_rise_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/ppsalign_timer.sv
// Pulse-length counter: runs while enabled, cleared otherwise.
module ppsalign_timer #(
   parameter int unsigned PULSE_CYCLES = 400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic last_o
);

   localparam int unsigned CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST_VAL = CW'(PULSE_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!en_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = en_i && (cnt_q == LAST_VAL);

   // R4: the counter never runs past the programmed length
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (cnt_q <= LAST_VAL));

endmodule

// File: rtl/ppsalign_fsm.sv
module ppsalign_fsm
   import ppsalign_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        trig_rise_i,
   input  logic        trig_lvl_i,
   input  logic        pps_rise_i,
   input  logic        last_i,
   output logic        pulse_o,
   output logic        sync_o,
   output logic        busy_o,
   output logic        done_o
);

   sync_state_e state_q, state_d;
   logic        done_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (trig_rise_i) state_d = ST_ARMED;
         ST_ARMED: if (pps_rise_i)  state_d = ST_PULSE;
         ST_PULSE: if (last_i)      state_d = ST_DONE;
         ST_DONE:  if (!trig_lvl_i) state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
      if (clr_i) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (clr_i)                                 done_q <= 1'b0;
         else if (state_q == ST_PULSE && last_i)    done_q <= 1'b1;
         else if (state_q == ST_IDLE && trig_rise_i) done_q <= 1'b0;
      end
   end

   assign pulse_o = (state_q == ST_PULSE);
   assign sync_o  = pulse_o;
   assign busy_o  = (state_q == ST_ARMED) || (state_q == ST_PULSE);
   assign done_o  = done_q;

   // R2: an idle trigger edge arms the block
   assert_arm_on_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && trig_rise_i && !clr_i) |=> busy_o);

   // R3: a pulse only starts from the armed state on a PPS edge
   assert_pulse_from_pps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_o) |-> $past(state_q == ST_ARMED && pps_rise_i));

   // R4: the pulse ends only at terminal count or by a clear
   assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_o) |-> $past(last_i || clr_i));

   // R6: trigger activity cannot disturb a running pulse
   assert_pulse_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PULSE && !last_i && !clr_i) |=> sync_o);

   // R7: done is sticky
   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !clr_i && !(state_q == ST_IDLE && trig_rise_i)) |=> done_o);

   // R8: no re-arm while the trigger is held high after a pulse
   assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE && trig_lvl_i && !clr_i) |=> (state_q == ST_DONE));

   // R9: clear returns everything to idle
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!sync_o && !busy_o && !done_o));

endmodule

// File: rtl/ppsalign_sync_gen.sv
module ppsalign_sync_gen #(
   parameter int unsigned CLK_HZ       = 200_000_000,
   parameter int unsigned PULSE_CYCLES = 400_000,
   parameter int          PPS_STAGES   = 2,
   parameter int          TRIG_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_clr_i,
   input  logic trig_i,
   input  logic pps_i,
   output logic sync_o,
   output logic busy_o,
   output logic done_o
);

   localparam int unsigned MIN_CYCLES = CLK_HZ / 1000;

   // R5: refuse a pulse shorter than 1 ms
   generate
      if (PULSE_CYCLES < MIN_CYCLES) begin : g_bad_len
         $error("ppsalign_sync_gen: PULSE_CYCLES below 1 ms (R5)");
      end
      if (PPS_STAGES < 2) begin : g_bad_pps
         $error("ppsalign_sync_gen: PPS needs at least two synchronizer stages");
      end
      if (TRIG_STAGES < 0) begin : g_bad_trig
         $error("ppsalign_sync_gen: TRIG_STAGES must be non-negative");
      end
   endgenerate

   logic pps_lvl, pps_rise;
   logic trig_lvl, trig_rise;
   logic pulse_en, tmr_last;

   ppsalign_edge #(.STAGES(PPS_STAGES)) u_pps_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pps_i),
      .lvl_o  (pps_lvl),
      .rise_o (pps_rise)
   );

   ppsalign_edge #(.STAGES(TRIG_STAGES)) u_trig_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (trig_i),
      .lvl_o  (trig_lvl),
      .rise_o (trig_rise)
   );

   ppsalign_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (pulse_en && !cnt_clr_i),
      .last_o (tmr_last)
   );

   ppsalign_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (cnt_clr_i),
      .trig_rise_i (trig_rise),
      .trig_lvl_i  (trig_lvl),
      .pps_rise_i  (pps_rise),
      .last_i      (tmr_last),
      .pulse_o     (pulse_en),
      .sync_o      (sync_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   // R10: an idle block never pulses, whatever PPS does
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cnt_clr_i) |=> !sync_o);

   // R11: sync high implies busy
   assert_sync_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |-> busy_o);

   logic unused_lvl;
   assign unused_lvl = pps_lvl;

endmodule

// File: tb/test_ppsalign_sync_gen.sv
`timescale 1ns/1ps
module test_ppsalign_sync_gen;

   localparam int CLK_HZ  = 10_000;
   localparam int PULSE_N = 20;
   localparam int MIN_N   = CLK_HZ / 1000;
   localparam int NVEC    = 4;
   localparam int VEC_WAIT [NVEC] = '{0, 1, 5, 40};
   localparam bit VEC_EXP  [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_clr = 1'b0;
   logic trig = 1'b0;
   logic pps = 1'b0;
   logic sync_w, busy_w, done_w;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ppsalign_sync_gen #(
      .CLK_HZ(CLK_HZ), .PULSE_CYCLES(PULSE_N)
   ) i_ppsalign_sync_gen (
      .clk(clk), .rst_n(rst_n), .cnt_clr_i(cnt_clr), .trig_i(trig),
      .pps_i(pps), .sync_o(sync_w), .busy_o(busy_w), .done_o(done_w)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_clr();
      cnt_clr = 1'b1;
      cyc(1);
      cnt_clr = 1'b0;
   endtask

   // Raise PPS for 3 cycles; return the sample index of the first high sync and the high count.
   task automatic pps_measure(input int win, output int first, output int len,
                              input bit toggle_trig);
      first = -1;
      len = 0;
      pps = 1'b1;
      for (int i = 1; i <= win; i++) begin
         @(negedge clk);
         if (sync_w) begin
            if (first < 0) first = i;
            len++;
         end
         if (i == 3) pps = 1'b0;
         if (toggle_trig && i == 6) trig = 1'b0;
         if (toggle_trig && i == 9) trig = 1'b1;
      end
   endtask

   initial begin
      int first, len;
      cyc(3);
      chk("R1 sync in reset", sync_w, 0);
      chk("R1 busy in reset", busy_w, 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 done after reset", done_w, 0);
      chk("R1 sync after reset", sync_w, 0);

      // Vector table: trigger-to-PPS delay versus expected pulse
      for (int v = 0; v < NVEC; v++) begin
         do_clr();
         trig = 1'b0;
         pps = 1'b0;
         cyc(4);
         trig = 1'b1;
         if (VEC_WAIT[v] > 0) cyc(VEC_WAIT[v]);
         if (VEC_WAIT[v] >= 3) chk("R2 armed busy", busy_w, 1);
         pps_measure(60, first, len, 1'b0);
         if (VEC_EXP[v]) begin
            chk("R12 sync latency", first, 3);
            chk("R4 pulse length", len, PULSE_N);
            chk("R5 pulse not below 1 ms", int'(len >= MIN_N), 1);
            chk("R7 done after pulse", done_w, 1);
            chk("R11 busy after pulse", busy_w, 0);
         end else begin
            chk("R3 early pps ignored", len, 0);
            chk("R11 still armed", busy_w, 1);
         end
      end

      // R8: trigger still high, second PPS edge must not pulse
      cyc(2);
      pps_measure(30, first, len, 1'b0);
      chk("R8 no retrigger while held", len, 0);
      chk("R7 done sticky", done_w, 1);
      trig = 1'b0;
      cyc(5);
      chk("R7 done kept after trig low", done_w, 1);
      chk("R8 idle not busy", busy_w, 0);

      // R10: PPS while idle
      pps_measure(30, first, len, 1'b0);
      chk("R10 idle pps ignored", len, 0);

      // R7 / R2: new trigger clears done and arms
      trig = 1'b1;
      cyc(3);
      chk("R2 busy 3 edges after trig", busy_w, 1);
      chk("R7 done cleared by trig", done_w, 0);

      // R6: toggle trigger while armed
      trig = 1'b0;
      cyc(4);
      trig = 1'b1;
      cyc(4);
      chk("R6 armed ignores trig", busy_w, 1);
      chk("R6 no sync while armed", sync_w, 0);
      // R6: toggle trigger while pulsing
      pps_measure(60, first, len, 1'b1);
      chk("R6 latency kept", first, 3);
      chk("R6 length kept", len, PULSE_N);

      // R9: clear in the middle of a pulse
      do_clr();
      trig = 1'b0;
      cyc(4);
      trig = 1'b1;
      cyc(4);
      pps = 1'b1;
      cyc(3);
      pps = 1'b0;
      cyc(5);
      chk("R9 pulse running", sync_w, 1);
      cnt_clr = 1'b1;
      cyc(1);
      cnt_clr = 1'b0;
      chk("R9 sync cleared", sync_w, 0);
      chk("R9 busy cleared", busy_w, 0);
      chk("R9 done cleared", done_w, 0);
      pps_measure(30, first, len, 1'b0);
      chk("R10 pps after clear ignored", len, 0);
      chk("R9 done stays clear", done_w, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule